// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This block works out where a word-addressed instruction stream goes next and how many execution cycles the current instruction costs. Each request carries the current program counter, a decoded operation kind, the raw relative-offset field, a status byte, an index into that byte, a single tested bit and a flag that says whether the instruction after the current one is two words long. From these it produces the next program counter, the cycle count and a flag saying whether control left the sequential path.

The operations covered are plain sequential advance, branches on any selected status bit being set or clear, signed and unsigned comparison branches, relative jump and relative call, and the two skip forms that jump over the next instruction when a tested bit is set or clear. Results are registered: a request presented with `op_valid` high on a rising edge is answered on the outputs right after that edge. A caller in the decode stage feeds one request per cycle and reads the answer one cycle later.

Top module: `bsu_branch_unit`

## Requirements
- R1: A taken branch, jump or call yields next_pc = pc + k + 1, where k is the sign-extended offset. A not-taken branch and the sequential kind (op_kind 0, and every code above 10) yield next_pc = pc + 1 with cycles = 1 and taken = 0.
- R2: A conditional branch costs 2 cycles when taken and 1 cycle when not taken. The taken output equals 1 exactly when the branch is taken.
- R3: Status byte layout is bit 7 I, 6 T, 5 H, 4 S, 3 V, 2 N, 1 Z, 0 C. Kind 3 (signed greater-or-equal) is taken when N XOR V is 0. Kind 4 (signed less-than) is taken when N XOR V is 1.
- R4: Kind 5 (unsigned same-or-higher) is taken when C is 0. Kind 6 (unsigned lower) is taken when C is 1.
- R5: Kind 1 is taken when status[flag_sel] is 1. Kind 2 is taken when status[flag_sel] is 0. flag_sel indexes the byte laid out as in R3.
- R6: When a skip condition holds, next_pc is pc + 2 with cycles = 2 if next_two_word is 0, and pc + 3 with cycles = 3 if next_two_word is 1. When it does not hold, next_pc is pc + 1 with cycles = 1. The advance always equals the cycle count.
- R7: Kind 9 skips when test_bit is 1. Kind 10 skips when test_bit is 0. taken is 1 exactly when a skip happens.
- R8: Kind 7 (relative jump) is always taken and costs 2 cycles. Kind 8 (relative call) is always taken and costs 3 cycles.
- R9: Branch kinds 1 to 6 use offset[6:0] as a 7-bit signed value and ignore offset[11:7]. Kinds 7 and 8 use all 12 bits of offset as a signed value.
- R10: next_pc wraps modulo 2^PC_W.
- R11: With op_valid high at a rising edge, res_valid is 1 after that edge and the outputs carry the result. With op_valid low, res_valid is 0 after the edge and next_pc, cycles and taken keep their values whatever the other inputs do.
- R12: While reset is asserted, res_valid, next_pc, cycles and taken are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present this cycle |
| op_kind | input | 4 | Operation kind code (see requirements) |
| pc | input | PC_W | Current program counter in words |
| offset | input | 12 | Raw relative offset field |
| flag_sel | input | 3 | Status bit index for kinds 1 and 2 |
| status | input | 8 | Status byte I T H S V N Z C, bit 7 down to bit 0 |
| test_bit | input | 1 | Tested bit for the skip kinds |
| next_two_word | input | 1 | Following instruction is two words long |
| res_valid | output | 1 | Result registered from a request |
| next_pc | output | PC_W | Next program counter |
| cycles | output | 2 | Execution cycles of the instruction |
| taken | output | 1 | Control left the sequential path |

## Verification
The flag branches are run with a one-hot status byte for every index, once with the matching index and once with a neighbouring one. This shows that the index picks the right bit and that the set and clear forms are not swapped. The comparison branches get all four N/V combinations and both carry values, which separates a XOR test from a single-flag test and signed from unsigned. Offsets with only the top bit of a field set, and a branch field padded with stray upper bits, show that sign extension is right and that the field width is correct. The skips cover all four combinations of tested bit and next-instruction length, and an idle cycle with changed inputs shows that the outputs hold.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [3:0] {
    OP_STEP     = 4'd0,
    OP_BR_FLAG1 = 4'd1,
    OP_BR_FLAG0 = 4'd2,
    OP_BR_SGE   = 4'd3,
    OP_BR_SLT   = 4'd4,
    OP_BR_UGE   = 4'd5,
    OP_BR_ULT   = 4'd6,
    OP_JUMP     = 4'd7,
    OP_CALL     = 4'd8,
    OP_SKIP1    = 4'd9,
    OP_SKIP0    = 4'd10
  } bsu_op_e;

  typedef enum logic [2:0] {
    CLS_STEP,
    CLS_BRANCH,
    CLS_JUMP,
    CLS_CALL,
    CLS_SKIP
  } bsu_cls_e;

  // status byte bit positions
  localparam int unsigned ST_C = 0;
  localparam int unsigned ST_Z = 1;
  localparam int unsigned ST_N = 2;
  localparam int unsigned ST_V = 3;
  localparam int unsigned ST_S = 4;
  localparam int unsigned ST_H = 5;
  localparam int unsigned ST_T = 6;
  localparam int unsigned ST_I = 7;

  localparam int unsigned STATUS_W = 8;
  localparam int unsigned SEL_W    = $clog2(STATUS_W);
  localparam int unsigned CYC_W    = 2;

endpackage

// File: rtl/bsu_cond.sv
module bsu_cond
  import bsu_pkg::*;
(
  input  logic [3:0]          op_kind,
  input  logic [SEL_W-1:0]    flag_sel,
  input  logic [STATUS_W-1:0] status,
  input  logic                test_bit,
  output bsu_cls_e            op_cls,
  output logic                cond_true
);

  logic [STATUS_W-1:0] sel_hot;
  logic                sel_flag;

  // one-hot decode of the selected status bit
  for (genvar g = 0; g < STATUS_W; g++) begin : g_sel
    assign sel_hot[g] = (flag_sel == SEL_W'(g));
  end
  assign sel_flag = |(sel_hot & status);

  always_comb begin
    op_cls    = CLS_STEP;
    cond_true = 1'b0;
    case (op_kind)
      OP_BR_FLAG1: begin op_cls = CLS_BRANCH; cond_true = sel_flag;                       end
      OP_BR_FLAG0: begin op_cls = CLS_BRANCH; cond_true = !sel_flag;                      end
      OP_BR_SGE:   begin op_cls = CLS_BRANCH; cond_true = !(status[ST_N] ^ status[ST_V]); end
      OP_BR_SLT:   begin op_cls = CLS_BRANCH; cond_true = status[ST_N] ^ status[ST_V];    end
      OP_BR_UGE:   begin op_cls = CLS_BRANCH; cond_true = !status[ST_C];                  end
      OP_BR_ULT:   begin op_cls = CLS_BRANCH; cond_true = status[ST_C];                   end
      OP_JUMP:     begin op_cls = CLS_JUMP;   cond_true = 1'b1;                           end
      OP_CALL:     begin op_cls = CLS_CALL;   cond_true = 1'b1;                           end
      OP_SKIP1:    begin op_cls = CLS_SKIP;   cond_true = test_bit;                       end
      OP_SKIP0:    begin op_cls = CLS_SKIP;   cond_true = !test_bit;                      end
      default:     begin op_cls = CLS_STEP;   cond_true = 1'b0;                           end
    endcase
  end

endmodule

// File: rtl/bsu_target.sv
module bsu_target #(
  parameter int unsigned PC_W      = 16,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned BR_OFF_W  = 7,
  parameter int unsigned JMP_OFF_W = 12
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  br_target,
  output logic [PC_W-1:0]  jmp_target,
  output logic [PC_W-1:0]  pc_plus1,
  output logic [PC_W-1:0]  pc_plus2,
  output logic [PC_W-1:0]  pc_plus3
);

  logic [BR_OFF_W-1:0]  br_raw;
  logic [JMP_OFF_W-1:0] jmp_raw;
  logic [PC_W-1:0]      br_ext;
  logic [PC_W-1:0]      jmp_ext;

  assign br_raw  = offset[BR_OFF_W-1:0];
  assign jmp_raw = offset[JMP_OFF_W-1:0];

  // sign extension, or truncation when the PC is narrower than a field
  if (PC_W > BR_OFF_W) begin : g_br_ext
    assign br_ext = {{(PC_W-BR_OFF_W){br_raw[BR_OFF_W-1]}}, br_raw};
  end else begin : g_br_trunc
    assign br_ext = br_raw[PC_W-1:0];
  end

  if (PC_W > JMP_OFF_W) begin : g_jmp_ext
    assign jmp_ext = {{(PC_W-JMP_OFF_W){jmp_raw[JMP_OFF_W-1]}}, jmp_raw};
  end else begin : g_jmp_trunc
    assign jmp_ext = jmp_raw[PC_W-1:0];
  end

  assign pc_plus1   = pc + PC_W'(1);
  assign pc_plus2   = pc + PC_W'(2);
  assign pc_plus3   = pc + PC_W'(3);
  assign br_target  = pc_plus1 + br_ext;
  assign jmp_target = pc_plus1 + jmp_ext;

endmodule

// File: rtl/bsu_branch_unit.sv
module bsu_branch_unit
  import bsu_pkg::*;
#(
  parameter int unsigned PC_W      = 16,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned BR_OFF_W  = 7,
  parameter int unsigned JMP_OFF_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [3:0]          op_kind,
  input  logic [PC_W-1:0]     pc,
  input  logic [OFF_W-1:0]    offset,
  input  logic [2:0]          flag_sel,
  input  logic [7:0]          status,
  input  logic                test_bit,
  input  logic                next_two_word,
  output logic                res_valid,
  output logic [PC_W-1:0]     next_pc,
  output logic [CYC_W-1:0]    cycles,
  output logic                taken
);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bsu_cls_e        op_cls;
  logic            cond_true;
  logic [PC_W-1:0] br_target, jmp_target, pc_plus1, pc_plus2, pc_plus3;

  bsu_cond u_cond (
    .op_kind   (op_kind),
    .flag_sel  (flag_sel),
    .status    (status),
    .test_bit  (test_bit),
    .op_cls    (op_cls),
    .cond_true (cond_true)
  );

  bsu_target #(
    .PC_W      (PC_W),
    .OFF_W     (OFF_W),
    .BR_OFF_W  (BR_OFF_W),
    .JMP_OFF_W (JMP_OFF_W)
  ) u_target (
    .pc         (pc),
    .offset     (offset),
    .br_target  (br_target),
    .jmp_target (jmp_target),
    .pc_plus1   (pc_plus1),
    .pc_plus2   (pc_plus2),
    .pc_plus3   (pc_plus3)
  );

  logic [PC_W-1:0]  pc_d;
  logic [CYC_W-1:0] cyc_d;
  logic             taken_d;

  // next-state selection
  always_comb begin
    pc_d    = pc_plus1;
    cyc_d   = CYC_W'(1);
    taken_d = 1'b0;
    case (op_cls)
      CLS_BRANCH: begin
        if (cond_true) begin
          pc_d    = br_target;
          cyc_d   = CYC_W'(2);
          taken_d = 1'b1;
        end
      end
      CLS_JUMP: begin
        pc_d    = jmp_target;
        cyc_d   = CYC_W'(2);
        taken_d = 1'b1;
      end
      CLS_CALL: begin
        pc_d    = jmp_target;
        cyc_d   = CYC_W'(3);
        taken_d = 1'b1;
      end
      CLS_SKIP: begin
        if (cond_true) begin
          taken_d = 1'b1;
          if (next_two_word) begin
            pc_d  = pc_plus3;
            cyc_d = CYC_W'(3);
          end else begin
            pc_d  = pc_plus2;
            cyc_d = CYC_W'(2);
          end
        end
      end
      default: begin
        pc_d    = pc_plus1;
        cyc_d   = CYC_W'(1);
        taken_d = 1'b0;
      end
    endcase
  end

  // result registers, loaded only when a request is present
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid <= 1'b0;
      next_pc   <= '0;
      cycles    <= '0;
      taken     <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        next_pc <= pc_d;
        cycles  <= cyc_d;
        taken   <= taken_d;
      end
    end
  end

endmodule

// File: rtl/bsu_branch_checks.sv
module bsu_branch_checks
  import bsu_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [3:0]       op_kind,
  input logic [PC_W-1:0]  pc,
  input logic [OFF_W-1:0] offset,
  input logic [2:0]       flag_sel,
  input logic [7:0]       status,
  input logic             test_bit,
  input logic             next_two_word,
  input logic             res_valid,
  input logic [PC_W-1:0]  next_pc,
  input logic [CYC_W-1:0] cycles,
  input logic             taken
);

  p_sge_not_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_BR_SGE && (status[ST_N] ^ status[ST_V]))
    |=> (!taken && cycles == CYC_W'(1) && next_pc == $past(pc) + PC_W'(1)));

  p_ult_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_BR_ULT && status[ST_C])
    |=> (taken && cycles == CYC_W'(2)));

  p_branch_cost_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind >= OP_BR_FLAG1 && op_kind <= OP_BR_ULT)
    |=> (cycles == (taken ? CYC_W'(2) : CYC_W'(1))));

  p_skip_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_kind == OP_SKIP1 || op_kind == OP_SKIP0))
    |=> ((next_pc - $past(pc)) == PC_W'(cycles)));

  p_skip_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_SKIP1 && !test_bit)
    |=> (!taken && cycles == CYC_W'(1)));

  p_jump_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_JUMP) |=> (taken && cycles == CYC_W'(2)));

  p_call_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_CALL) |=> (taken && cycles == CYC_W'(3)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid) |=> (!res_valid && $stable(next_pc) && $stable(cycles) && $stable(taken)));

  p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

endmodule

bind bsu_branch_unit bsu_branch_checks #(.PC_W(PC_W), .OFF_W(OFF_W)) u_checks (.*);

// File: tb/bsu_branch_unit_test.sv
`timescale 1ns/1ps
module bsu_branch_unit_test;

  localparam int PC_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              op_valid;
  logic [3:0]        op_kind;
  logic [PC_W-1:0]   pc;
  logic [11:0]       offset;
  logic [2:0]        flag_sel;
  logic [7:0]        status;
  logic              test_bit;
  logic              next_two_word;
  logic              res_valid;
  logic [PC_W-1:0]   next_pc;
  logic [1:0]        cycles;
  logic              taken;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bsu_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .pc(pc), .offset(offset), .flag_sel(flag_sel), .status(status),
    .test_bit(test_bit), .next_two_word(next_two_word),
    .res_valid(res_valid), .next_pc(next_pc), .cycles(cycles), .taken(taken)
  );

  function automatic logic [15:0] br_tgt(input logic [15:0] p, input logic [11:0] o);
    return p + {{9{o[6]}}, o[6:0]} + 16'd1;
  endfunction

  function automatic logic [15:0] jmp_tgt(input logic [15:0] p, input logic [11:0] o);
    return p + {{4{o[11]}}, o} + 16'd1;
  endfunction

  task automatic check(input string tag, input logic [15:0] exp_pc,
                       input logic [1:0] exp_cyc, input logic exp_tk);
    checks++;
    if (res_valid !== 1'b1 || next_pc !== exp_pc || cycles !== exp_cyc || taken !== exp_tk) begin
      errors++;
      $display("FAIL %s: got valid=%b pc=%h cyc=%0d tk=%b, expected valid=1 pc=%h cyc=%0d tk=%b",
               tag, res_valid, next_pc, cycles, taken, exp_pc, exp_cyc, exp_tk);
    end
  endtask

  // drive one request at a falling edge, sample at the next falling edge
  task automatic issue(input logic [3:0] k, input logic [15:0] p, input logic [11:0] o,
                       input logic [2:0] sel, input logic [7:0] st,
                       input logic tb, input logic two);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; pc = p; offset = o;
    flag_sel = sel; status = st; test_bit = tb; next_two_word = two;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    checks++;
    if (res_valid !== 1'b0 || next_pc !== 16'h0 || cycles !== 2'd0 || taken !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: got valid=%b pc=%h cyc=%0d tk=%b, expected 0 0000 0 0",
               res_valid, next_pc, cycles, taken);
    end
  endtask

  task automatic t_step;
    issue(4'd0, 16'h1234, 12'h0, 3'd0, 8'h0, 1'b0, 1'b0);
    check("R1 step", 16'h1235, 2'd1, 1'b0);
    issue(4'd13, 16'h0200, 12'h7FF, 3'd0, 8'hFF, 1'b1, 1'b1);
    check("R1 unused code", 16'h0201, 2'd1, 1'b0);
  endtask

  task automatic t_flag_branches;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] st;
      st = 8'b1 << i;
      issue(4'd1, 16'h0400, 12'h005, 3'(i), st, 1'b0, 1'b0);
      check($sformatf("R5 R2 set-form hit bit %0d", i), br_tgt(16'h0400, 12'h005), 2'd2, 1'b1);
      issue(4'd1, 16'h0400, 12'h005, 3'((i + 1) % 8), st, 1'b0, 1'b0);
      check($sformatf("R5 R2 set-form miss bit %0d", i), 16'h0401, 2'd1, 1'b0);
      issue(4'd2, 16'h0400, 12'h07E, 3'((i + 1) % 8), st, 1'b0, 1'b0);
      check($sformatf("R5 R1 clear-form hit bit %0d", i), br_tgt(16'h0400, 12'h07E), 2'd2, 1'b1);
      issue(4'd2, 16'h0400, 12'h07E, 3'(i), st, 1'b0, 1'b0);
      check($sformatf("R5 clear-form miss bit %0d", i), 16'h0401, 2'd1, 1'b0);
    end
  endtask

  task automatic t_signed;
    for (int nv = 0; nv < 4; nv++) begin
      logic [7:0] st;
      logic       x;
      st = 8'h0;
      st[2] = nv[0];
      st[3] = nv[1];
      x = nv[0] ^ nv[1];
      issue(4'd3, 16'h0800, 12'h010, 3'd0, st, 1'b0, 1'b0);
      check($sformatf("R3 ge nv=%0d", nv), x ? 16'h0801 : br_tgt(16'h0800, 12'h010),
            x ? 2'd1 : 2'd2, !x);
      issue(4'd4, 16'h0800, 12'h010, 3'd0, st, 1'b0, 1'b0);
      check($sformatf("R3 lt nv=%0d", nv), x ? br_tgt(16'h0800, 12'h010) : 16'h0801,
            x ? 2'd2 : 2'd1, x);
    end
  endtask

  task automatic t_unsigned;
    issue(4'd5, 16'h0900, 12'h020, 3'd0, 8'hFE, 1'b0, 1'b0);
    check("R4 same-or-higher C=0", br_tgt(16'h0900, 12'h020), 2'd2, 1'b1);
    issue(4'd5, 16'h0900, 12'h020, 3'd0, 8'h01, 1'b0, 1'b0);
    check("R4 same-or-higher C=1", 16'h0901, 2'd1, 1'b0);
    issue(4'd6, 16'h0900, 12'h020, 3'd0, 8'h01, 1'b0, 1'b0);
    check("R4 lower C=1", br_tgt(16'h0900, 12'h020), 2'd2, 1'b1);
    issue(4'd6, 16'h0900, 12'h020, 3'd0, 8'hFE, 1'b0, 1'b0);
    check("R4 lower C=0", 16'h0901, 2'd1, 1'b0);
  endtask

  task automatic t_jump_call;
    issue(4'd7, 16'h1000, 12'h800, 3'd0, 8'h0, 1'b0, 1'b0);
    check("R8 R9 jump -2048", 16'h0801, 2'd2, 1'b1);
    issue(4'd8, 16'h1000, 12'h7FF, 3'd0, 8'h0, 1'b0, 1'b0);
    check("R8 R9 call +2047", 16'h1800, 2'd3, 1'b1);
  endtask

  task automatic t_branch_field;
    issue(4'd5, 16'h0100, 12'hFC0, 3'd0, 8'h00, 1'b0, 1'b0);
    check("R9 branch -64 upper bits ignored", 16'h00C1, 2'd2, 1'b1);
    issue(4'd5, 16'h0100, 12'hF3F, 3'd0, 8'h00, 1'b0, 1'b0);
    check("R9 branch +63 upper bits ignored", 16'h0140, 2'd2, 1'b1);
  endtask

  task automatic t_wrap;
    issue(4'd0, 16'hFFFF, 12'h0, 3'd0, 8'h0, 1'b0, 1'b0);
    check("R10 step wrap", 16'h0000, 2'd1, 1'b0);
    issue(4'd6, 16'hFFF0, 12'h03F, 3'd0, 8'h01, 1'b0, 1'b0);
    check("R10 branch wrap", 16'h0030, 2'd2, 1'b1);
    issue(4'd7, 16'h0002, 12'hFF0, 3'd0, 8'h0, 1'b0, 1'b0);
    check("R10 jump below zero", 16'hFFF3, 2'd2, 1'b1);
    issue(4'd9, 16'hFFFE, 12'h0, 3'd0, 8'h0, 1'b1, 1'b1);
    check("R10 skip wrap", 16'h0001, 2'd3, 1'b1);
  endtask

  task automatic t_skip;
    for (int c = 0; c < 4; c++) begin
      logic tb, two;
      tb  = c[0];
      two = c[1];
      issue(4'd9, 16'h2000, 12'h0, 3'd0, 8'h0, tb, two);
      check($sformatf("R6 R7 skip-if-set tb=%b two=%b", tb, two),
            !tb ? 16'h2001 : (two ? 16'h2003 : 16'h2002),
            !tb ? 2'd1 : (two ? 2'd3 : 2'd2), tb);
      issue(4'd10, 16'h2000, 12'h0, 3'd0, 8'h0, tb, two);
      check($sformatf("R6 R7 skip-if-clear tb=%b two=%b", tb, two),
            tb ? 16'h2001 : (two ? 16'h2003 : 16'h2002),
            tb ? 2'd1 : (two ? 2'd3 : 2'd2), !tb);
    end
  endtask

  task automatic t_idle_hold;
    issue(4'd8, 16'h3000, 12'h004, 3'd0, 8'h0, 1'b0, 1'b0);
    check("R11 load before idle", 16'h3005, 2'd3, 1'b1);
    @(negedge clk);
    op_kind = 4'd0; pc = 16'h5555; status = 8'hFF; test_bit = 1'b1;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || next_pc !== 16'h3005 || cycles !== 2'd3 || taken !== 1'b1) begin
      errors++;
      $display("FAIL R11 idle hold: got valid=%b pc=%h cyc=%0d tk=%b, expected 0 3005 3 1",
               res_valid, next_pc, cycles, taken);
    end
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_kind = '0; pc = '0; offset = '0;
    flag_sel = '0; status = '0; test_bit = 1'b0; next_two_word = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_step();
    t_flag_branches();
    t_signed();
    t_unsigned();
    t_jump_call();
    t_branch_field();
    t_wrap();
    t_skip();
    t_idle_hold();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule